// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder, 32 Bits

This block is a purely combinational 32-bit binary adder. It takes two operands and a carry-in, and returns the 32-bit sum, the carry-out and a signed (two's complement) overflow flag.

Carries are not passed from bit to bit. The word is divided into four 8-bit groups. Each group works out the carry into every one of its bit positions straight from per-bit generate and propagate terms. These terms are combined as flat sums of products, one product per possible carry source.

A second lookahead unit of the same form forms the carry into each group. Its inputs are the group generate and group propagate terms and the external carry-in. The group terms and the whole-word generate and propagate terms are also brought out, so a wider adder can use this block as a cascade stage.

The block has no clock, no state and no reset. Every output is a function of the present operand and carry-in values only. Any integration that needs a register stage adds it around the block.

Top module: `cla_adder32`

## Requirements
- R1: `sum_out` equals (`opd_a` + `opd_b` + `carry_in`) modulo 2^32 for every input combination.
- R2: `carry_out` equals bit 32 of the 33-bit result of `opd_a` + `opd_b` + `carry_in`.
- R3: `ovf_out` is 1 exactly when `opd_a[31]` equals `opd_b[31]` and `sum_out[31]` differs from them. This is the same as the carry into bit 31 XOR the carry out of bit 31.
- R4: Group k covers bits 8k+7 down to 8k, with k from 0 to 3. `grp_prop[k]` is 1 exactly when every bit of `opd_a ^ opd_b` in group k is 1.
- R5: `grp_gen[k]` is 1 exactly when adding the group-k bytes of `opd_a` and `opd_b` with no carry-in gives a result of 256 or more.
- R6: `word_prop` is 1 exactly when all 32 bits of `opd_a ^ opd_b` are 1. `word_gen` is 1 exactly when `opd_a` + `opd_b`, with no carry-in, is 2^32 or more.
- R7: A carry-in meets a chain of propagate positions across all four groups (`opd_a` = 0xFFFFFFFF, `opd_b` = 0, `carry_in` = 1). The result is `sum_out` = 0 and `carry_out` = 1.
- R8: No group is ever both generating and fully propagating: `grp_gen[k]` and `grp_prop[k]` are never 1 together.
- R9: The outputs depend only on the current inputs. All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First operand |
| opd_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of bit 31 |
| ovf_out | output | 1 | Signed overflow flag |
| grp_prop | output | 4 | Propagate term of each 8-bit group |
| grp_gen | output | 4 | Generate term of each 8-bit group |
| word_prop | output | 1 | Propagate term of the whole word |
| word_gen | output | 1 | Generate term of the whole word |

## Verification
The hardest case to reach from the ports is a carry that must cross every group boundary through the second-level unit. That happens only when all 32 propagate terms are 1 together, and random operands almost never produce it. The stimulus therefore drives operand pairs whose XOR is all ones, both with and without a carry-in.

It also drives the signed boundary sums: most-positive plus one, and most-negative plus most-negative. A sweep sets one group to generate while the groups above it propagate, so that each second-level carry equation is reached on its own.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // Width of one lookahead group and number of groups in the word.
    localparam int CLA_GROUP_W  = 8;
    localparam int CLA_N_GROUPS = 4;
endpackage

// File: rtl/cla_pg.sv
// Per-bit generate and propagate terms (propagate in XOR form, reused for the sum).
module cla_pg #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    assign gen_o  = a_i & b_i;
    assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/cla_lookahead.sv
// Flattened lookahead unit: each carry is a single sum of products of
// generate/propagate terms; nothing ripples between positions.
module cla_lookahead #(
    parameter int W = 8
) (
    input  logic [W-1:0] gen_i,
    input  logic [W-1:0] prop_i,
    input  logic         cin,
    output logic [W-1:0] carry_o,
    output logic         blk_gen,
    output logic         blk_prop
);
    logic [W:0] gen_part;
    logic [W:0] prop_part;

    always_comb begin
        logic acc;
        logic term;
        logic allp;
        for (int k = 0; k <= W; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = gen_i[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & prop_i[m];
                end
                acc = acc | term;
            end
            allp = 1'b1;
            for (int m = 0; m < k; m++) begin
                allp = allp & prop_i[m];
            end
            gen_part[k]  = acc;
            prop_part[k] = allp;
        end
    end

    for (genvar k = 0; k < W; k++) begin : g_carry
        assign carry_o[k] = gen_part[k] | (prop_part[k] & cin);
    end

    assign blk_gen  = gen_part[W];
    assign blk_prop = prop_part[W];
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32 #(
    parameter int GROUP_W  = cla_pkg::CLA_GROUP_W,
    parameter int N_GROUPS = cla_pkg::CLA_N_GROUPS
) (
    input  logic [GROUP_W*N_GROUPS-1:0] opd_a,
    input  logic [GROUP_W*N_GROUPS-1:0] opd_b,
    input  logic                        carry_in,
    output logic [GROUP_W*N_GROUPS-1:0] sum_out,
    output logic                        carry_out,
    output logic                        ovf_out,
    output logic [N_GROUPS-1:0]         grp_prop,
    output logic [N_GROUPS-1:0]         grp_gen,
    output logic                        word_prop,
    output logic                        word_gen
);
    localparam int DATA_W = GROUP_W * N_GROUPS;

    logic [DATA_W-1:0]   bit_gen;
    logic [DATA_W-1:0]   bit_prop;
    logic [DATA_W-1:0]   bit_carry;
    logic [N_GROUPS-1:0] grp_carry;

    // Second level: carries entering each group from group terms.
    cla_lookahead #(.W(N_GROUPS)) u_level2 (
        .gen_i    (grp_gen),
        .prop_i   (grp_prop),
        .cin      (carry_in),
        .carry_o  (grp_carry),
        .blk_gen  (word_gen),
        .blk_prop (word_prop)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        cla_pg #(.W(GROUP_W)) u_pg (
            .a_i    (opd_a[g*GROUP_W +: GROUP_W]),
            .b_i    (opd_b[g*GROUP_W +: GROUP_W]),
            .gen_o  (bit_gen[g*GROUP_W +: GROUP_W]),
            .prop_o (bit_prop[g*GROUP_W +: GROUP_W])
        );

        cla_lookahead #(.W(GROUP_W)) u_level1 (
            .gen_i    (bit_gen[g*GROUP_W +: GROUP_W]),
            .prop_i   (bit_prop[g*GROUP_W +: GROUP_W]),
            .cin      (grp_carry[g]),
            .carry_o  (bit_carry[g*GROUP_W +: GROUP_W]),
            .blk_gen  (grp_gen[g]),
            .blk_prop (grp_prop[g])
        );
    end

    assign sum_out   = bit_prop ^ bit_carry;
    assign carry_out = word_gen | (word_prop & carry_in);
    assign ovf_out   = bit_carry[DATA_W-1] ^ carry_out;
endmodule

// File: rtl/cla_adder32_chk.sv
module cla_adder32_chk #(
    parameter int GROUP_W  = 8,
    parameter int N_GROUPS = 4
) (
    input logic [GROUP_W*N_GROUPS-1:0] opd_a,
    input logic [GROUP_W*N_GROUPS-1:0] opd_b,
    input logic                        carry_in,
    input logic [GROUP_W*N_GROUPS-1:0] sum_out,
    input logic                        carry_out,
    input logic                        ovf_out,
    input logic [N_GROUPS-1:0]         grp_prop,
    input logic [N_GROUPS-1:0]         grp_gen,
    input logic                        word_prop,
    input logic                        word_gen
);
    localparam int DATA_W = GROUP_W * N_GROUPS;

    logic [DATA_W:0] ref_sum;
    assign ref_sum = {1'b0, opd_a} + {1'b0, opd_b} + {{DATA_W{1'b0}}, carry_in};

    always_comb begin
        if (!$isunknown({opd_a, opd_b, carry_in})) begin
            // R1 R2
            sum_match_chk: assert ({carry_out, sum_out} == ref_sum)
                else $error("sum/carry mismatch");
            // R3
            ovf_rule_chk: assert (ovf_out == ((opd_a[DATA_W-1] == opd_b[DATA_W-1]) &&
                                              (sum_out[DATA_W-1] != opd_a[DATA_W-1])))
                else $error("overflow flag wrong");
            // R8
            grp_excl_chk: assert ((grp_gen & grp_prop) == '0)
                else $error("group both generates and propagates");
            // R6
            word_gen_chk: assert (!word_gen || carry_out)
                else $error("word generate without carry out");
            // R6
            word_prop_chk: assert (!word_prop || (carry_out == carry_in))
                else $error("word propagate does not pass carry");
        end
    end
endmodule

bind cla_adder32 cla_adder32_chk #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS)) u_chk (.*);

// File: tb/cla_adder32_bench.sv
module cla_adder32_bench;
    logic        clk = 1'b0;
    logic [31:0] opd_a = '0;
    logic [31:0] opd_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] sum_out;
    logic        carry_out, ovf_out, word_prop, word_gen;
    logic [3:0]  grp_prop, grp_gen;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cla_adder32 u_cla_adder32 (
        .opd_a(opd_a), .opd_b(opd_b), .carry_in(carry_in),
        .sum_out(sum_out), .carry_out(carry_out), .ovf_out(ovf_out),
        .grp_prop(grp_prop), .grp_gen(grp_gen),
        .word_prop(word_prop), .word_gen(word_gen)
    );

    task automatic check(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h cin=%0d actual=%0h expected=%0h",
                     req, opd_a, opd_b, carry_in, got, exp);
        end
    endtask

    // Drive on the rising edge, compare against the behavioural model on the falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        longint full;
        logic [3:0] e_gp, e_gg;
        logic e_ovf;
        @(posedge clk);
        opd_a = a; opd_b = b; carry_in = c;
        @(negedge clk);
        full = longint'(a) + longint'(b) + longint'(c);
        e_ovf = (a[31] == b[31]) && (full[31] != a[31]);
        for (int k = 0; k < 4; k++) begin
            e_gp[k] = ((a[k*8 +: 8] ^ b[k*8 +: 8]) == 8'hFF);
            e_gg[k] = ((int'(a[k*8 +: 8]) + int'(b[k*8 +: 8])) > 255);
        end
        check("R1 sum", longint'(sum_out), full & 64'hFFFF_FFFF);
        check("R2 carry_out", longint'(carry_out), (full >> 32) & 1);
        check("R3 overflow", longint'(ovf_out), longint'(e_ovf));
        check("R4 grp_prop", longint'(grp_prop), longint'(e_gp));
        check("R5 grp_gen", longint'(grp_gen), longint'(e_gg));
        check("R6 word_prop", longint'(word_prop), longint'((a ^ b) == 32'hFFFF_FFFF));
        check("R6 word_gen", longint'(word_gen),
              longint'((longint'(a) + longint'(b)) > 64'hFFFF_FFFF));
        check("R8 exclusive", longint'(grp_prop & grp_gen), 0);
    endtask

    initial begin
        // R9: all-zero inputs give all-zero outputs
        @(negedge clk);
        check("R9 idle sum", longint'(sum_out), 0);
        check("R9 idle flags", longint'({carry_out, ovf_out, grp_prop, grp_gen, word_prop, word_gen}), 0);

        // R7: carry-in crossing all four groups
        apply(32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R7 wrap sum", longint'(sum_out), 0);
        check("R7 wrap carry", longint'(carry_out), 1);
        apply(32'hFFFF_FFFF, 32'h0, 1'b0);
        apply(32'hFFFF_FFFF, 32'h1, 1'b0);
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        // R3: signed boundaries
        apply(32'h7FFF_FFFF, 32'h1, 1'b0);
        check("R3 maxpos+1", longint'(ovf_out), 1);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0);
        check("R3 minneg+minneg", longint'(ovf_out), 1);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        apply(32'hFFFF_FFFB, 32'h0000_0005, 1'b0);
        // R5: one group generates, the groups above it propagate
        for (int g = 0; g < 4; g++) begin
            logic [31:0] a, b;
            a = 32'hFFFF_FFFF << (8 * g);
            b = 32'h0000_0001 << (8 * g);
            apply(a, b, 1'b0);
            apply(a ^ (32'h1 << (8 * g)), 32'h0, 1'b1);
        end
        // R1: random operands
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 1'($urandom));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule